// File: doc/BRIEF.md
# Eight-Line Prioritized Interrupt Controller

The controller watches eight interrupt request lines and drives one interrupt output to a processor. Each line passes through three stages. An edge-sense stage remembers the level the line had at the previous clock. A request register records pending requests. An in-service register records requests the processor has taken but not yet finished. A mask register gates the request bits after they are latched. A fixed-priority resolver then decides whether the interrupt output is raised. Line 0 has the highest priority.

The processor answers the interrupt output with two acknowledge pulses. The first pulse picks the winning line: it clears that line's request bit and sets its in-service bit. The second pulse returns an 8-bit vector, equal to a base value plus the line number. When the software handler finishes, it writes an end-of-interrupt command, which clears the highest-priority in-service bit. A request can be withdrawn after the output was raised but before the first pulse. In that case the controller still completes the handshake, but it hands back the vector of line 7 and marks nothing in service. Software can detect this by reading the in-service register.

A single mode bit selects edge or level triggering. Writes go through a small register port. A read port returns the mask, the request bits, the in-service bits and the mode bit.

Top module: `intc8_top`

## Requirements
- R1: After reset: `int_out` and `vec_valid` are 0, the request and in-service registers read 0, the mask reads all ones (every line masked), and the mode bit reads 0 (edge mode).
- R2: In edge mode, a line that is low at one clock edge and high at the next sets its request bit at that second edge. If the line is unmasked and nothing of equal or higher priority is in service, `int_out` is 1 in the same cycle.
- R3: A masked line still sets its request bit, but it never raises `int_out`. Mask bit i gates line i.
- R4: Line 0 has the highest priority. An `inta` pulse taken while no acknowledge is open clears the winning request bit and sets its in-service bit. The next `inta` pulse makes `vec_out` equal `VEC_BASE` plus the line number, with `vec_valid` high for exactly one cycle. The in-service register changes only on an acknowledge or an end-of-interrupt.
- R5: A pending unmasked request raises `int_out` only when its line number is lower than every set in-service bit. `int_out` is 0 between the first and the second acknowledge pulse.
- R6: A request may be withdrawn, so that no unmasked request qualifies at the first acknowledge pulse. In that case the second pulse returns `VEC_BASE`+7 and no in-service bit is set.
- R7: A write to address 1 is an end-of-interrupt. It clears the lowest-numbered set in-service bit and no other bit.
- R8: In edge mode, a request bit that an acknowledge has cleared stays 0 while its line is held high. It sets again only on a new rising edge.
- R9: In level mode (mode bit 1), each request bit takes the line's level at every edge. It is set again after an acknowledge while the line stays high, and it clears when the line drops.
- R10: In both modes, a request that has not been acknowledged clears when its line drops. Without acknowledge pulses, `vec_valid` is never raised.
- R11: Write address 0 loads the mask, write address 2 loads the mode from data bit 0, and write address 3 has no effect. Read address 0 returns the mask, 1 the request bits, 2 the in-service bits, and 3 the mode in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Request lines, line 0 highest priority |
| inta | input | 1 | Acknowledge pulse, one per clock cycle high |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last completed acknowledge |
| vec_valid | output | 1 | One-cycle strobe when `vec_out` is updated |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
The directed cases cover the following:
- Two lines raised at different times, which distinguishes priority order from arrival order.
- A higher-priority line arriving while a lower one is in service, which separates nesting from blocking.
- A request dropped after `int_out` rose, which separates a proper vector from the line-7 default.
- A line held high across an end-of-interrupt, which separates edge behaviour from level behaviour.

Random phases then flip lines sparsely, change the mask and mode, and issue end-of-interrupts and acknowledges, some of them with no request pending. A cycle model in the bench computes the expected outputs for every cycle. Sparse flips leave requests standing long enough to be acknowledged. Acknowledges without a request exercise the default path over and over.

// File: rtl/intc8_pkg.sv
// Shared constants and types for the eight-line interrupt controller.
// Assumes a two-bit register address space.
package intc8_pkg;

    // Write addresses
    localparam logic [1:0] WA_MASK = 2'd0;
    localparam logic [1:0] WA_EOI  = 2'd1;
    localparam logic [1:0] WA_MODE = 2'd2;

    // Read addresses
    localparam logic [1:0] RA_MASK = 2'd0;
    localparam logic [1:0] RA_REQ  = 2'd1;
    localparam logic [1:0] RA_SVC  = 2'd2;
    localparam logic [1:0] RA_MODE = 2'd3;

    // Acknowledge handshake phase
    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_WAIT2 = 1'b1
    } ack_phase_t;

endpackage

// File: rtl/intc8_capture.sv
// Edge-sense stage and request register.
// Edge mode sets a bit on a low-to-high change between two clock edges.
// Level mode copies the line at every edge.
// In both modes a bit clears when its line drops.
// Bits named by ack_clr are cleared at the same edge.
// Assumes the request lines are already synchronous to clk.
module intc8_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_mode,
    input  logic [N-1:0] irq,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);

    logic [N-1:0] sense_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] irr_next;

    // Next request value before the acknowledge clear is applied
    always_comb begin
        if (level_mode)
            irr_next = irq;
        else
            irr_next = (irr_q | (irq & ~sense_q)) & irq;
    end

    // Edge-sense memory and request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            irr_q   <= '0;
        end else begin
            sense_q <= irq;
            irr_q   <= irr_next & ~ack_clr;
        end
    end

    assign irr = irr_q;

endmodule

// File: rtl/intc8_resolver.sv
// Fixed-priority resolver, with line 0 highest.
// Gates the request bits with the mask.
// Finds the best pending line and the best in-service line.
// Flags a request when the pending line beats every in-service bit.
// Purely combinational.
module intc8_resolver #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  isr,
    output logic          req,
    output logic [IW-1:0] win
);

    localparam int IW1 = IW + 1;

    logic [N-1:0]   pend;
    logic [IW1-1:0] p_idx;
    logic [IW1-1:0] s_idx;

    assign pend = irr & ~mask;

    // Lowest set index of pending and in-service bits; N means none
    always_comb begin
        p_idx = IW1'(N);
        s_idx = IW1'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) p_idx = IW1'(i);
            if (isr[i])  s_idx = IW1'(i);
        end
    end

    assign req = (p_idx < s_idx);
    assign win = p_idx[IW-1:0];

endmodule

// File: rtl/intc8_service.sv
// Acknowledge sequencer and in-service register.
// The first inta pulse freezes the winner, or the last line if nothing
// qualifies, and sets the winner's in-service bit.
// The second pulse issues the vector.
// End-of-interrupt clears the lowest set in-service bit.
// Assumes inta pulses are sampled one per cycle.
module intc8_service #(
    parameter int               N        = 8,
    parameter int               IW       = $clog2(N),
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta,
    input  logic             req,
    input  logic [IW-1:0]    win,
    input  logic             eoi,
    output logic [N-1:0]     isr,
    output logic [N-1:0]     ack_clr,
    output logic             idle,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);

    import intc8_pkg::*;

    ack_phase_t       phase_q;
    logic [IW-1:0]    line_q;
    logic [N-1:0]     isr_q;
    logic [N-1:0]     eoi_clr;
    logic [VEC_W-1:0] vec_q;
    logic             vv_q;

    // One-hot of the winner when the first pulse is taken with a request
    always_comb begin
        ack_clr = '0;
        if (inta && phase_q == ACK_IDLE && req)
            ack_clr[win] = 1'b1;
    end

    // Lowest set in-service bit, selected on end-of-interrupt
    assign eoi_clr = eoi ? (isr_q & (~isr_q + 1'b1)) : '0;

    // Handshake phase, frozen line, in-service bits and vector output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ACK_IDLE;
            line_q  <= '0;
            isr_q   <= '0;
            vec_q   <= '0;
            vv_q    <= 1'b0;
        end else begin
            vv_q  <= 1'b0;
            isr_q <= (isr_q & ~eoi_clr) | ack_clr;
            if (inta) begin
                if (phase_q == ACK_IDLE) begin
                    phase_q <= ACK_WAIT2;
                    line_q  <= req ? win : IW'(N - 1);
                end else begin
                    phase_q <= ACK_IDLE;
                    vec_q   <= VEC_BASE + VEC_W'(line_q);
                    vv_q    <= 1'b1;
                end
            end
        end
    end

    assign isr       = isr_q;
    assign idle      = (phase_q == ACK_IDLE);
    assign vec_out   = vec_q;
    assign vec_valid = vv_q;

endmodule

// File: rtl/intc8_top.sv
// Eight-line prioritized interrupt controller top.
// Holds the mask and mode registers and the register read mux.
// Connects the capture, resolver and service stages.
// The interrupt output is raised only while no acknowledge is open.
module intc8_top #(
    parameter int               N        = 8,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic             inta,
    output logic             int_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [N-1:0]     wr_data,
    input  logic [1:0]       rd_addr,
    output logic [N-1:0]     rd_data
);

    import intc8_pkg::*;

    localparam int IW = $clog2(N);

    logic [N-1:0]  mask_q;
    logic          level_q;
    logic [N-1:0]  irr_q;
    logic [N-1:0]  isr_q;
    logic [N-1:0]  ack_clr;
    logic          req;
    logic [IW-1:0] win;
    logic          idle;
    logic          eoi;

    assign eoi = wr_en && (wr_addr == WA_EOI);

    // Mask and trigger mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            level_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == WA_MASK) mask_q  <= wr_data;
            if (wr_addr == WA_MODE) level_q <= wr_data[0];
        end
    end

    intc8_capture #(.N(N)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_mode (level_q),
        .irq        (irq_in),
        .ack_clr    (ack_clr),
        .irr        (irr_q)
    );

    intc8_resolver #(.N(N), .IW(IW)) u_res (
        .irr  (irr_q),
        .mask (mask_q),
        .isr  (isr_q),
        .req  (req),
        .win  (win)
    );

    intc8_service #(.N(N), .IW(IW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .inta      (inta),
        .req       (req),
        .win       (win),
        .eoi       (eoi),
        .isr       (isr_q),
        .ack_clr   (ack_clr),
        .idle      (idle),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    assign int_out = req && idle;

    // Register read mux
    always_comb begin
        case (rd_addr)
            RA_MASK: rd_data = mask_q;
            RA_REQ:  rd_data = irr_q;
            RA_SVC:  rd_data = isr_q;
            default: rd_data = {{(N-1){1'b0}}, level_q};
        endcase
    end

endmodule

// File: rtl/intc8_chk.sv
// Property checker for the interrupt controller.
// It is bound into every instance of the top module.
module intc8_chk #(
    parameter int               N        = 8,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inta,
    input logic             int_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [N-1:0]     irr,
    input logic [N-1:0]     isr,
    input logic [N-1:0]     mask
);

    logic [N-1:0] pend;
    logic [N-1:0] isr_low;

    assign pend    = irr & ~mask;
    assign isr_low = isr & (~isr + 1'b1);

    // R3
    int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (pend != '0));

    // R5
    int_beats_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((isr == '0) || ((pend & (isr_low - 1'b1)) != '0)));

    // R4
    vec_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));

    // R4
    vec_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R4
    vec_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_out >= VEC_BASE) && (vec_out < VEC_BASE + VEC_W'(N))));

    // R4
    svc_grows_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> ($countones(isr) <= $countones($past(isr))));

    // R7
    eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && !inta && isr != '0)
        |=> ($countones(isr) + 1 == $countones($past(isr))));

endmodule

bind intc8_top intc8_chk #(.N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta      (inta),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irr       (irr_q),
    .isr       (isr_q),
    .mask      (mask_q)
);

// File: tb/sim_intc8_top.sv
`timescale 1ns/1ps
// Bench for intc8_top: directed corner cases first, then a random phase
// compared every cycle against a cycle model built from the requirements.
module sim_intc8_top;

    localparam logic [7:0] VB = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       inta = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    wire        int_out;
    wire  [7:0] vec_out;
    wire        vec_valid;
    wire  [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    intc8_top #(.N(8), .VEC_W(8), .VEC_BASE(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .inta(inta),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Cycle model state
    logic [7:0] m_prev, m_irr, m_isr, m_mask, m_vec;
    logic       m_level, m_st, m_vv;
    int         m_line;

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_int();
        return !m_st && (lowest(m_irr & ~m_mask) < lowest(m_isr));
    endfunction

    // Model update at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = '0; m_irr = '0; m_isr = '0; m_mask = '1; m_vec = '0;
            m_level = 1'b0; m_st = 1'b0; m_vv = 1'b0; m_line = 0;
        end else begin
            int p, s;
            logic [7:0] irr_n, isr_n;
            p = lowest(m_irr & ~m_mask);
            s = lowest(m_isr);
            irr_n = m_level ? irq : ((m_irr | (irq & ~m_prev)) & irq);
            isr_n = m_isr;
            if (wr_en && wr_addr == 2'd1 && s < 8) isr_n[s] = 1'b0;
            m_vv = 1'b0;
            if (inta && !m_st) begin
                if (p < s) begin
                    irr_n[p] = 1'b0;
                    isr_n[p] = 1'b1;
                    m_line = p;
                end else begin
                    m_line = 7;
                end
            end else if (inta && m_st) begin
                m_vv = 1'b1;
                m_vec = VB + 8'(m_line);
            end
            if (inta) m_st = !m_st;
            if (wr_en && wr_addr == 2'd0) m_mask = wr_data;
            if (wr_en && wr_addr == 2'd2) m_level = wr_data[0];
            m_prev = irq;
            m_irr = irr_n;
            m_isr = isr_n;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        inta = 1'b1;
        tick();
        inta = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
        logic [7:0] d;
        rd(a, d);
        check(d == e, tag, d, e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq = '0; inta = 1'b0; wr_en = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        void'($urandom(32'd2718));
        do_reset();

        // R1 reset state
        check(int_out == 1'b0, "R1 int_out", int_out, 0);
        check(vec_valid == 1'b0, "R1 vec_valid", vec_valid, 0);
        chk_reg(2'd1, 8'h00, "R1 request");
        chk_reg(2'd2, 8'h00, "R1 in-service");
        chk_reg(2'd0, 8'hFF, "R1 mask");
        chk_reg(2'd3, 8'h00, "R1 mode");

        wr(2'd0, 8'h00);
        chk_reg(2'd0, 8'h00, "R11 mask readback");
        wr(2'd3, 8'hFF);
        chk_reg(2'd0, 8'h00, "R11 address 3 write ignored mask");
        chk_reg(2'd3, 8'h00, "R11 address 3 write ignored mode");

        // R2 edge capture on line 3
        irq = 8'h08; tick();
        chk_reg(2'd1, 8'h08, "R2 request set");
        check(int_out == 1'b1, "R2 int raised", int_out, 1);

        // R4 line 3 wins although line 6 is pending
        irq = 8'h48; tick();
        pulse();
        chk_reg(2'd2, 8'h08, "R4 in-service after first pulse");
        chk_reg(2'd1, 8'h40, "R4 request cleared");
        check(int_out == 1'b0, "R5 int low during handshake", int_out, 0);
        pulse();
        check(vec_valid == 1'b1, "R4 vec_valid", vec_valid, 1);
        check(vec_out == VB + 8'd3, "R4 vector line 3", vec_out, VB + 8'd3);
        check(int_out == 1'b0, "R5 lower priority blocked", int_out, 0);
        tick();
        check(vec_valid == 1'b0, "R4 vec_valid one cycle", vec_valid, 0);

        // R5 nesting by line 1
        irq = 8'h4A; tick();
        check(int_out == 1'b1, "R5 higher priority nests", int_out, 1);
        pulse(); pulse();
        check(vec_out == VB + 8'd1, "R5 nested vector", vec_out, VB + 8'd1);
        chk_reg(2'd2, 8'h0A, "R5 two in service");

        // R7 end-of-interrupt order
        wr(2'd1, 8'h00);
        chk_reg(2'd2, 8'h08, "R7 first clears line 1");
        wr(2'd1, 8'h00);
        chk_reg(2'd2, 8'h00, "R7 second clears line 3");
        chk_reg(2'd1, 8'h40, "R8 held lines stay clear");
        check(int_out == 1'b1, "R5 line 6 now served", int_out, 1);

        // R10 withdraw without acknowledge, then R6 default vector
        irq = 8'h0A; tick();
        chk_reg(2'd1, 8'h00, "R10 request follows line");
        check(int_out == 1'b0, "R10 int dropped", int_out, 0);
        tick();
        check(vec_valid == 1'b0, "R10 no vector without ack", vec_valid, 0);
        pulse();
        chk_reg(2'd2, 8'h00, "R6 nothing in service");
        pulse();
        check(vec_out == VB + 8'd7, "R6 default vector", vec_out, VB + 8'd7);

        // R8 new rising edge on line 1 is captured
        irq = 8'h08; tick();
        irq = 8'h0A; tick();
        chk_reg(2'd1, 8'h02, "R8 re-armed by new edge");
        pulse(); pulse();
        check(vec_out == VB + 8'd1, "R8 vector", vec_out, VB + 8'd1);
        wr(2'd1, 8'h00);

        // R3 masked line 0
        wr(2'd0, 8'h01);
        irq = 8'h0B; tick();
        chk_reg(2'd1, 8'h01, "R3 masked line latched");
        check(int_out == 1'b0, "R3 masked no int", int_out, 0);

        // R9 level mode
        wr(2'd0, 8'h00);
        check(int_out == 1'b1, "R3 unmask raises int", int_out, 1);
        wr(2'd2, 8'h01);
        chk_reg(2'd3, 8'h01, "R11 mode readback");
        pulse(); pulse();
        check(vec_out == VB, "R9 vector line 0", vec_out, VB);
        chk_reg(2'd1, 8'h0B, "R9 request mirrors lines");
        chk_reg(2'd2, 8'h01, "R9 line 0 in service");
        wr(2'd1, 8'h00);
        check(int_out == 1'b1, "R9 re-request after eoi", int_out, 1);
        irq = 8'h00; tick();
        chk_reg(2'd1, 8'h00, "R9 drop clears");

        // Random phase checked against the cycle model
        for (int run = 0; run < 2; run++) begin
            do_reset();
            for (int cyc = 0; cyc < 3000; cyc++) begin
                logic [7:0] a, b;
                check(int_out == exp_int(), "R5 random int_out", int_out, exp_int());
                check(vec_valid == m_vv, "R4 random vec_valid", vec_valid, m_vv);
                if (m_vv) check(vec_out == m_vec, "R4 random vector", vec_out, m_vec);
                rd(2'd1, a);
                check(a == m_irr, "R2 random request", a, m_irr);
                rd(2'd2, b);
                check(b == m_isr, "R7 random in-service", b, m_isr);
                irq = irq ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
                wr_en = ($urandom % 10) == 0;
                wr_addr = 2'($urandom % 3);
                wr_data = (wr_addr == 2'd2) ? 8'(($urandom % 4) == 0) :
                          8'($urandom) & 8'($urandom);
                if (m_st) inta = ($urandom % 2) == 0;
                else if (int_out) inta = ($urandom % 3) == 0;
                else inta = ($urandom % 40) == 0;
                tick();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule